// File: doc/BRIEF.md
# Byte-Addressed GPIO Port with Set/Clear/Toggle Aliases

This block is an 8-bit general-purpose I/O port controlled through nine byte addresses on a simple synchronous register bus. It holds two control registers. The drive-enable register chooses which pins are driven outputs. The drive-level register holds the value put on those pins. Each control register has three extra addresses. A write to one of them sets, clears or inverts only the bits that are 1 in the written byte, so software can change some pins with one store and no read-modify-write. A read of any of those extra addresses returns the register they act on.

A ninth address reads the pin levels after a two-flop synchronizer. A pin that is driven as an output therefore reads back its own driven value. The bus has no back-pressure: every access finishes in a single cycle. Read data is registered and appears one cycle after the read is presented. It holds its value until the next read.

Top module: `gpio_alias_port`

## Requirements
- R1: After reset, both control registers are 0x00, so pin_oe and pin_out are 0x00 and bus_rdata is 0x00.
- R2: A write to offset 0 loads the drive-enable register with bus_wdata, and a write to offset 4 loads the drive-level register with bus_wdata.
- R3: A write to offset 1 (drive-enable) or offset 5 (drive-level) ORs bus_wdata into that register.
- R4: A write to offset 2 (drive-enable) or offset 6 (drive-level) clears in that register every bit that is 1 in bus_wdata.
- R5: A write to offset 3 (drive-enable) or offset 7 (drive-level) inverts in that register every bit that is 1 in bus_wdata.
- R6: A write to offsets 0 to 3 never changes the drive-level register, and a write to offsets 4 to 7 never changes the drive-enable register.
- R7: A read of offsets 1, 2 or 3 returns the drive-enable register, and a read of offsets 5, 6 or 7 returns the drive-level register.
- R8: A read of offset 8 returns pin_in through a two-stage synchronizer. A read captured on the second rising edge after a pin change still returns the old level, and a read captured on the third edge returns the new level.
- R9: Writes to offsets 8 to 15 change no register, and reads of offsets 9 to 15 return 0x00.
- R10: bus_rdata is valid one cycle after bus_rd is asserted and holds while bus_rd is low. A read and a write to the same register in one cycle returns the value from before the write.
- R11: pin_oe always equals the drive-enable register and pin_out always equals the drive-level register, and both change only in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_out | output | 8 | Value driven on each pin |
| pin_oe | output | 8 | Output enable for each pin |
| pin_in | input | 8 | Pin levels seen from outside |

## Verification
On every cycle, the assertions check the arithmetic of each alias write as seen at pin_oe and pin_out. They also check that a write to one register group leaves the other unchanged, that out-of-range writes are ignored, and that alias and unmapped reads return the right value. Read-data hold is checked on every cycle as well. Only the bench scenarios can show the reset values and the exact synchronizer lag on the input path. The same goes for loop-back of driven pins through offset 8 and the old-value result of a read that collides with a write.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;
  localparam int unsigned OFS_W = 4;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_FLIP = 2'd3
  } alias_op_e;

  localparam logic [OFS_W-1:0] OFS_DRV_EN  = 4'd0;
  localparam logic [OFS_W-1:0] OFS_DRV_LVL = 4'd4;
  localparam logic [OFS_W-1:0] OFS_PINS    = 4'd8;
endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_alias_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter logic [OFS_W-1:0] BASE = 4'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [OFS_W-1:0] addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     q
);
  logic      hit;
  alias_op_e op;
  logic [W-1:0] nxt;

  assign hit = wr && (addr[OFS_W-1:2] == BASE[OFS_W-1:2]);
  assign op  = alias_op_e'(addr[1:0]);

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = wdata;
      OP_SET:  nxt = q | wdata;
      OP_CLR:  nxt = q & ~wdata;
      OP_FLIP: nxt = q ^ wdata;
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (hit) q <= nxt;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
  import gpio_alias_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  logic [OFS_W-1:0] addr,
  input  logic [W-1:0]     drv_en,
  input  logic [W-1:0]     drv_lvl,
  input  logic [W-1:0]     pins,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr[OFS_W-1:2] == OFS_DRV_EN[OFS_W-1:2])       sel = drv_en;
    else if (addr[OFS_W-1:2] == OFS_DRV_LVL[OFS_W-1:2]) sel = drv_lvl;
    else if (addr == OFS_PINS)                          sel = pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= sel;
  end
endmodule

// File: rtl/gpio_alias_port.sv
module gpio_alias_port
  import gpio_alias_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  output logic [W-1:0]     pin_out,
  output logic [W-1:0]     pin_oe,
  input  logic [W-1:0]     pin_in
);
  logic [W-1:0] drv_en_q, drv_lvl_q, pins_q;

  gpio_alias_reg #(.W(W), .BASE(OFS_DRV_EN)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .q(drv_en_q)
  );

  gpio_alias_reg #(.W(W), .BASE(OFS_DRV_LVL)) u_lvl (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .q(drv_lvl_q)
  );

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_q)
  );

  gpio_rd_port #(.W(W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .addr(bus_addr),
    .drv_en(drv_en_q), .drv_lvl(drv_lvl_q), .pins(pins_q), .rdata(bus_rdata)
  );

  assign pin_oe  = drv_en_q;
  assign pin_out = drv_lvl_q;
endmodule

// File: rtl/gpio_alias_port_chk.sv
module gpio_alias_port_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   bus_addr,
  input logic         bus_wr,
  input logic         bus_rd,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd4) |=> pin_out == $past(bus_wdata));

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd1) |=> pin_oe == ($past(pin_oe) | $past(bus_wdata)));

  assert_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd6) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));

  assert_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd7) |=> pin_out == ($past(pin_out) ^ $past(bus_wdata)));

  assert_isolate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr < 4'd4) |=> $stable(pin_out));

  assert_alias_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr >= 4'd5 && bus_addr <= 4'd7) |=> bus_rdata == $past(pin_out));

  assert_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr >= 4'd8) |=> ($stable(pin_out) && $stable(pin_oe)));

  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr > 4'd8) |=> bus_rdata == '0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_alias_port gpio_alias_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/test_gpio_alias_port.sv
`timescale 1ns/1ps
module test_gpio_alias_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, pin_out, pin_oe, pin_in;
  logic [7:0] ext = '0;
  int vectors = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_alias_port i_gpio_alias_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] q);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    q = bus_rdata;
    bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] apply(input int op, input logic [7:0] b, input logic [7:0] d);
    case (op)
      1: return b | d;
      2: return b & ~d;
      3: return b ^ d;
      default: return d;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] q, a, b, c, e, hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
    rd(4'd0, q); chk("R1 drive-enable", q, 8'h00);
    rd(4'd4, q); chk("R1 drive-level", q, 8'h00);

    // R2..R7, R11 sweep over both groups, three aliases, value grid
    for (int g = 0; g < 2; g++) begin
      for (int op = 1; op < 4; op++) begin
        for (int ia = 0; ia < 16; ia++) begin
          for (int ib = 0; ib < 16; ib++) begin
            logic [3:0] base, other;
            a = 8'(ia * 17);
            b = 8'((ib * 37 + 11) & 255);
            c = ~a ^ 8'(ib);
            base  = (g == 0) ? 4'd0 : 4'd4;
            other = (g == 0) ? 4'd4 : 4'd0;
            wr(other, c);
            wr(base, a);
            chk("R2 load", (g == 0) ? pin_oe : pin_out, a);
            wr(base + 4'(op), b);
            e = apply(op, a, b);
            chk(op == 1 ? "R3 set" : op == 2 ? "R4 clear" : "R5 toggle",
                (g == 0) ? pin_oe : pin_out, e);
            chk("R6 other group", (g == 0) ? pin_out : pin_oe, c);
            rd(base, q); chk("R11 base readback", q, e);
            for (int k = 1; k < 4; k++) begin
              rd(base + 4'(k), q); chk("R7 alias read", q, e);
            end
          end
        end
      end
    end

    // R8 input path with synchronizer lag and loopback
    wr(4'd0, 8'h00);
    ext = 8'h3C;
    repeat (3) @(negedge clk);
    rd(4'd8, q); chk("R8 steady pins", q, 8'h3C);
    ext = 8'hC3;
    @(negedge clk);
    rd(4'd8, q); chk("R8 second edge old", q, 8'h3C);
    rd(4'd8, q); chk("R8 third edge new", q, 8'hC3);
    wr(4'd4, 8'hA5);
    wr(4'd0, 8'hF0);
    repeat (3) @(negedge clk);
    rd(4'd8, q); chk("R8 loopback", q, 8'hA3);

    // R9 ignored writes and unmapped reads
    for (int k = 8; k < 16; k++) begin
      wr(4'(k), 8'hFF);
      chk("R9 oe untouched", pin_oe, 8'hF0);
      chk("R9 out untouched", pin_out, 8'hA5);
    end
    for (int k = 9; k < 16; k++) begin
      rd(4'(k), q); chk("R9 unmapped read", q, 8'h00);
    end
    rd(4'd8, q); chk("R9 pins unchanged", q, 8'hA3);

    // R10 hold and read/write collision
    rd(4'd4, hold);
    chk("R10 read level", hold, 8'hA5);
    repeat (4) @(negedge clk);
    chk("R10 hold", bus_rdata, 8'hA5);
    wr(4'd0, 8'h11);
    bus_addr = 4'd0; bus_wdata = 8'h77; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R10 collision old", bus_rdata, 8'h11);
    rd(4'd2, q); chk("R10 after collision", q, 8'h77);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule